// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block decides, for every bus access, whether the address falls inside a 4 KB on-chip peripheral window whose position in a 24-bit address space is chosen by software at run time. The window position lives in a 16-bit base register. The base register itself sits at a fixed low address, next to a handful of other fixed configuration locations that this block also decodes. For a window hit it reports the 12-bit offset and which of three areas is addressed: system RAM, parameter RAM or internal registers.

Until software writes the base register, the window does not decode, even though the register reads back a non-zero reset value. An optional function-code compare restricts the window to one address space. When the bus runs 8 bits wide, only the write of the low base byte opens the window. An external device that also claims a window address raises a sticky conflict flag and, if enabled, a bus-error request. Chip-select style external enables are inhibited for any access that this block owns.

The decode is purely combinational from the bus inputs and the stored state, so there is no stream handshake and no back-pressure. Every access is answered in the cycle it is presented, and state updates land on the following clock edge.

Top module: `periph_window_decoder`

## Requirements
- R1: A total reset (`rst_req` and `halt_req` both high at a clock edge) sets `base_rd` to 16'hBFFF, closes the window so that `win_hit` stays 0 for every address, clears `conflict_stat` and clears the bus-error enable.
- R2: A reset request without halt changes none of the stored state: base value, window-open state, conflict status and enable are all kept.
- R3: An access is one with `addr_valid` high, `rd_en` or `wr_en` high, and at least one byte lane set. `ub_en` selects the even byte on `wdata[15:8]` and `lb_en` selects the odd byte on `wdata[7:0]`. A supervisor data access (`fc` = 5) with address bits 23..12 all zero raises `cfg_sel[i]` when an enabled lane's byte address lies in register i. The ranges are: 0 = $0F0–$0F1, 1 = $0F2–$0F3, 2 = $0F4–$0F6, 3 = $0F7, 4 = $0F8–$0F9, 5 = $0FA, 6 = $0FB. This decode works whether the window is open or closed.
- R4: The base register is written only through `cfg_sel[1]` with `wr_en`. The `ub_en` lane stores `wdata[15:8]` into bits 15..8 and the `lb_en` lane stores `wdata[7:0]` into bits 7..0. Accesses with any other function code leave it unchanged.
- R5: `win_hit` is high when an access occurs, the window is open, and address bits 23..12 equal base bits 11..0.
- R6: When base bit 12 is 1, a hit also needs `fc` equal to base bits 15..13. When base bit 12 is 0, those bits are ignored.
- R7: On a hit, `win_offset` = address bits 11..0 and `win_region` is 0 for offsets $000–$3FF, 1 for $400–$7FF and 2 for $800–$FFF. Without a hit both outputs are 0.
- R8: With `bus8_mode` = 0, any base-register byte write opens the window. With `bus8_mode` = 1, only a write that includes the low lane opens it. A write of the high byte alone does not.
- R9: A fixed configuration select takes priority: while any `cfg_sel` bit is high, `win_hit` is 0.
- R10: `ext_claim` during a window hit sets `conflict_stat` on the next edge. A write to $0F4 on the `ub_en` lane with `wdata[8]` = 1 clears it. A new conflict in the same cycle wins over the clear.
- R11: `bus_err_req` = window hit, `ext_claim` and the enable bit all high. The enable is stored from `wdata[9]` by any `ub_en` write to $0F4.
- R12: `ext_cs_inhibit` is high whenever `win_hit` or any `cfg_sel` bit is high.
- R13: With `addr_valid` low, or with neither `rd_en` nor `wr_en` set, no hit, select, inhibit or state change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_req | input | 1 | Reset request; total reset only together with halt |
| halt_req | input | 1 | Halt request |
| addr_valid | input | 1 | Address strobe qualifying the access |
| addr | input | 24 | Byte address |
| fc | input | 3 | Function code (address space) |
| ub_en | input | 1 | Even byte lane enable (data 15..8) |
| lb_en | input | 1 | Odd byte lane enable (data 7..0) |
| rd_en | input | 1 | Read access |
| wr_en | input | 1 | Write access |
| bus8_mode | input | 1 | 1 when the external bus is 8 bits wide |
| wdata | input | 16 | Write data |
| ext_claim | input | 1 | External device also decodes this address |
| win_hit | output | 1 | Access falls inside the open window |
| win_offset | output | 12 | Offset within the window on a hit |
| win_region | output | 2 | 0 system RAM, 1 parameter RAM, 2 internal registers |
| cfg_sel | output | 7 | One bit per fixed configuration register |
| base_rd | output | 16 | Current base register value |
| conflict_stat | output | 1 | Sticky decode-conflict status |
| bus_err_req | output | 1 | Bus-error request on an enabled conflict |
| ext_cs_inhibit | output | 1 | Suppress external chip-select enables |

## Verification
The assertions check on every cycle that a hit always lies in the stored page, honours the function-code compare and never coexists with a configuration select. They also check that selects occur only in supervisor data space, that a bus error always has a conflicting claim behind it, that a conflict is remembered on the next edge, and that the base value holds when it is not written. Only the bench scenarios can show that the window stays closed after a total reset despite the $BFFF read-back. The same holds for the difference in opening rules between 8-bit and 16-bit modes, for a reset without halt preserving the window, and for write-one-to-clear of the conflict status.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  localparam int NUM_CFG  = 7;
  localparam int CFG_AW   = 12;
  localparam int IDX_BASE = 1;
  localparam int IDX_SCTL = 2;

  // Byte ranges of the fixed configuration registers, index 0 in the low slot.
  localparam logic [NUM_CFG-1:0][CFG_AW-1:0] CFG_LO =
    {12'h0FB, 12'h0FA, 12'h0F8, 12'h0F7, 12'h0F4, 12'h0F2, 12'h0F0};
  localparam logic [NUM_CFG-1:0][CFG_AW-1:0] CFG_HI =
    {12'h0FB, 12'h0FA, 12'h0F9, 12'h0F7, 12'h0F6, 12'h0F3, 12'h0F1};

  typedef enum logic [1:0] {
    RGN_SYSRAM = 2'd0,
    RGN_PARAM  = 2'd1,
    RGN_REGS   = 2'd2
  } region_e;

endpackage

// File: rtl/pwd_cfg_decode.sv
module pwd_cfg_decode
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-2:0]  word_addr,
  input  logic               ub_en,
  input  logic               lb_en,
  input  logic               access_ok,
  output logic [NUM_CFG-1:0] sel
);

  logic              upper_zero;
  logic [CFG_AW-1:0] even_a;
  logic [CFG_AW-1:0] odd_a;

  assign upper_zero = (word_addr[ADDR_W-2:CFG_AW-1] == '0);
  assign even_a     = {word_addr[CFG_AW-2:0], 1'b0};
  assign odd_a      = {word_addr[CFG_AW-2:0], 1'b1};

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic even_in;
    logic odd_in;
    assign even_in = ub_en && (even_a >= CFG_LO[g]) && (even_a <= CFG_HI[g]);
    assign odd_in  = lb_en && (odd_a  >= CFG_LO[g]) && (odd_a  <= CFG_HI[g]);
    assign sel[g]  = access_ok && upper_zero && (even_in || odd_in);
  end

endmodule

// File: rtl/pwd_window_match.sv
module pwd_window_match
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 12,
  parameter int FC_W   = 3,
  parameter int BASE_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [FC_W-1:0]   fc,
  input  logic              access,
  input  logic              armed,
  input  logic              cfg_any,
  input  logic [BASE_W-1:0] base,
  output logic              hit,
  output logic [OFF_W-1:0]  offset,
  output region_e           region
);

  localparam int PAGE_W  = ADDR_W - OFF_W;
  localparam int CMP_BIT = PAGE_W;

  logic page_ok;
  logic fc_ok;

  assign page_ok = (addr[ADDR_W-1:OFF_W] == base[PAGE_W-1:0]);
  assign fc_ok   = !base[CMP_BIT] || (fc == base[BASE_W-1:CMP_BIT+1]);
  assign hit     = access && armed && !cfg_any && page_ok && fc_ok;
  assign offset  = hit ? addr[OFF_W-1:0] : '0;

  always_comb begin
    region = RGN_SYSRAM;
    if (hit) begin
      unique case (addr[OFF_W-1:OFF_W-2])
        2'b00:   region = RGN_SYSRAM;
        2'b01:   region = RGN_PARAM;
        default: region = RGN_REGS;
      endcase
    end
  end

endmodule

// File: rtl/pwd_base_reg.sv
module pwd_base_reg #(
  parameter int              BASE_W    = 16,
  parameter logic [BASE_W-1:0] RESET_VAL = 16'hBFFF
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              bus8,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] base_q,
  output logic              armed
);

  localparam int HALF = BASE_W / 2;

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      base_q <= RESET_VAL;
      armed  <= 1'b0;
    end else begin
      if (wr_hi) base_q[BASE_W-1:HALF] <= wdata[BASE_W-1:HALF];
      if (wr_lo) base_q[HALF-1:0]      <= wdata[HALF-1:0];
      // Narrow bus: only the low byte completes the register.
      if (wr_lo || (wr_hi && !bus8)) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/pwd_conflict.sv
module pwd_conflict (
  input  logic clk,
  input  logic sys_rst,
  input  logic detect,
  input  logic ctl_wr,
  input  logic clr_bit,
  input  logic en_bit,
  output logic stat,
  output logic en
);

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      stat <= 1'b0;
      en   <= 1'b0;
    end else begin
      if (detect)                stat <= 1'b1;
      else if (ctl_wr && clr_bit) stat <= 1'b0;
      if (ctl_wr) en <= en_bit;
    end
  end

endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder
  import pwd_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                OFF_W     = 12,
  parameter int                FC_W      = 3,
  parameter int                DATA_W    = 16,
  parameter logic [FC_W-1:0]   SUPV_FC   = 3'd5,
  parameter logic [DATA_W-1:0] BASE_RST  = 16'hBFFF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'h0000F4,
  parameter int                STAT_BIT  = 8,
  parameter int                EN_BIT    = 9
) (
  input  logic              clk,
  input  logic              rst_req,
  input  logic              halt_req,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FC_W-1:0]   fc,
  input  logic              ub_en,
  input  logic              lb_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              bus8_mode,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ext_claim,
  output logic              win_hit,
  output logic [OFF_W-1:0]  win_offset,
  output logic [1:0]        win_region,
  output logic [NUM_CFG-1:0] cfg_sel,
  output logic [DATA_W-1:0] base_rd,
  output logic              conflict_stat,
  output logic              bus_err_req,
  output logic              ext_cs_inhibit
);

  logic    sys_rst;
  logic    access;
  logic    supv_access;
  logic    cfg_any;
  logic    base_wr;
  logic    ctl_wr;
  logic    armed;
  logic    detect;
  logic    conf_en;
  region_e rgn;

  assign sys_rst     = rst_req && halt_req;
  assign access      = addr_valid && (rd_en || wr_en) && (ub_en || lb_en);
  assign supv_access = access && (fc == SUPV_FC);

  pwd_cfg_decode #(.ADDR_W(ADDR_W)) u_cfg (
    .word_addr (addr[ADDR_W-1:1]),
    .ub_en     (ub_en),
    .lb_en     (lb_en),
    .access_ok (supv_access),
    .sel       (cfg_sel)
  );

  assign cfg_any = |cfg_sel;
  assign base_wr = wr_en && cfg_sel[IDX_BASE];
  assign ctl_wr  = wr_en && ub_en && cfg_sel[IDX_SCTL] &&
                   (addr[ADDR_W-1:1] == CTRL_ADDR[ADDR_W-1:1]);

  pwd_base_reg #(.BASE_W(DATA_W), .RESET_VAL(BASE_RST)) u_base (
    .clk     (clk),
    .sys_rst (sys_rst),
    .wr_hi   (base_wr && ub_en),
    .wr_lo   (base_wr && lb_en),
    .bus8    (bus8_mode),
    .wdata   (wdata),
    .base_q  (base_rd),
    .armed   (armed)
  );

  pwd_window_match #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FC_W(FC_W), .BASE_W(DATA_W)
  ) u_win (
    .addr    (addr),
    .fc      (fc),
    .access  (access),
    .armed   (armed),
    .cfg_any (cfg_any),
    .base    (base_rd),
    .hit     (win_hit),
    .offset  (win_offset),
    .region  (rgn)
  );

  assign win_region = rgn;
  assign detect     = win_hit && ext_claim;

  pwd_conflict u_conf (
    .clk     (clk),
    .sys_rst (sys_rst),
    .detect  (detect),
    .ctl_wr  (ctl_wr),
    .clr_bit (wdata[STAT_BIT]),
    .en_bit  (wdata[EN_BIT]),
    .stat    (conflict_stat),
    .en      (conf_en)
  );

  assign bus_err_req    = detect && conf_en;
  assign ext_cs_inhibit = win_hit || cfg_any;

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 12,
  parameter int FC_W   = 3,
  parameter int DATA_W = 16,
  parameter int NCFG   = 7
) (
  input logic              clk,
  input logic              rst_req,
  input logic              halt_req,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr,
  input logic [FC_W-1:0]   fc,
  input logic              rd_en,
  input logic              wr_en,
  input logic              ext_claim,
  input logic              win_hit,
  input logic [OFF_W-1:0]  win_offset,
  input logic [NCFG-1:0]   cfg_sel,
  input logic [DATA_W-1:0] base_rd,
  input logic              conflict_stat,
  input logic              bus_err_req,
  input logic              ext_cs_inhibit
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  p_hit_needs_bus_r13: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    win_hit |-> (addr_valid && (rd_en || wr_en)));

  p_cfg_beats_win_r9: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    (|cfg_sel) |-> !win_hit);

  p_cfg_supervisor_r3: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    (|cfg_sel) |-> (fc == 3'd5));

  p_page_match_r5: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    win_hit |-> (addr[ADDR_W-1:OFF_W] == base_rd[PAGE_W-1:0]));

  p_fc_compare_r6: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    (win_hit && base_rd[PAGE_W]) |-> (fc == base_rd[DATA_W-1:PAGE_W+1]));

  p_offset_idle_r7: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    !win_hit |-> (win_offset == '0));

  p_sticky_conflict_r10: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    (win_hit && ext_claim) |=> conflict_stat);

  p_berr_cause_r11: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    bus_err_req |-> (win_hit && ext_claim));

  p_cs_inhibit_r12: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    (win_hit || (|cfg_sel)) |-> ext_cs_inhibit);

  p_base_hold_r4: assert property (@(posedge clk) disable iff (rst_req && halt_req)
    !(wr_en && cfg_sel[1]) |=> $stable(base_rd));

endmodule

bind periph_window_decoder pwd_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FC_W(FC_W), .DATA_W(DATA_W), .NCFG(pwd_pkg::NUM_CFG)
) u_chk (
  .clk            (clk),
  .rst_req        (rst_req),
  .halt_req       (halt_req),
  .addr_valid     (addr_valid),
  .addr           (addr),
  .fc             (fc),
  .rd_en          (rd_en),
  .wr_en          (wr_en),
  .ext_claim      (ext_claim),
  .win_hit        (win_hit),
  .win_offset     (win_offset),
  .cfg_sel        (cfg_sel),
  .base_rd        (base_rd),
  .conflict_stat  (conflict_stat),
  .bus_err_req    (bus_err_req),
  .ext_cs_inhibit (ext_cs_inhibit)
);

// File: tb/periph_window_decoder_bench.sv
module periph_window_decoder_bench;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_req, halt_req, addr_valid, ub_en, lb_en, rd_en, wr_en;
  logic        bus8_mode, ext_claim;
  logic [23:0] addr;
  logic [2:0]  fc;
  logic [15:0] wdata;
  logic        win_hit, conflict_stat, bus_err_req, ext_cs_inhibit;
  logic [11:0] win_offset;
  logic [1:0]  win_region;
  logic [6:0]  cfg_sel;
  logic [15:0] base_rd;

  periph_window_decoder u_periph_window_decoder (
    .clk(clk), .rst_req(rst_req), .halt_req(halt_req), .addr_valid(addr_valid),
    .addr(addr), .fc(fc), .ub_en(ub_en), .lb_en(lb_en), .rd_en(rd_en),
    .wr_en(wr_en), .bus8_mode(bus8_mode), .wdata(wdata), .ext_claim(ext_claim),
    .win_hit(win_hit), .win_offset(win_offset), .win_region(win_region),
    .cfg_sel(cfg_sel), .base_rd(base_rd), .conflict_stat(conflict_stat),
    .bus_err_req(bus_err_req), .ext_cs_inhibit(ext_cs_inhibit)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic        b8 = 1'b0;
  logic [15:0] m_base;
  logic        m_armed, m_stat, m_en;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [6:0] byte_reg(input logic [23:0] b);
    logic [6:0] r = '0;
    if (b[23:12] == 12'h000) begin
      case (b[11:0])
        12'h0F0, 12'h0F1:          r[0] = 1'b1;
        12'h0F2, 12'h0F3:          r[1] = 1'b1;
        12'h0F4, 12'h0F5, 12'h0F6: r[2] = 1'b1;
        12'h0F7:                   r[3] = 1'b1;
        12'h0F8, 12'h0F9:          r[4] = 1'b1;
        12'h0FA:                   r[5] = 1'b1;
        12'h0FB:                   r[6] = 1'b1;
        default:                   r    = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [6:0] exp_cfg(input logic [23:0] a, input logic [2:0] f,
                                         input logic u, input logic l, input logic acc);
    logic [6:0] r = '0;
    if (acc && f == 3'd5) begin
      if (u) r = r | byte_reg({a[23:1], 1'b0});
      if (l) r = r | byte_reg({a[23:1], 1'b1});
    end
    return r;
  endfunction

  task automatic cyc(input string tag, input logic v, input logic [23:0] a,
                     input logic [2:0] f, input logic u, input logic l,
                     input logic r, input logic w, input logic [15:0] d,
                     input logic claim, input logic rs, input logic hl);
    logic       acc, e_hit, ctl, s_next;
    logic [6:0] e_cfg;
    logic [1:0] e_rgn;
    @(negedge clk);
    addr_valid = v; addr = a; fc = f; ub_en = u; lb_en = l; rd_en = r; wr_en = w;
    wdata = d; ext_claim = claim; rst_req = rs; halt_req = hl; bus8_mode = b8;
    #2;
    acc   = v && (r || w) && (u || l);
    e_cfg = exp_cfg(a, f, u, l, acc);
    e_hit = acc && m_armed && (e_cfg == 7'd0) && (a[23:12] == m_base[11:0]) &&
            (!m_base[12] || f == m_base[15:13]);
    e_rgn = !e_hit ? 2'd0 : (a[11] ? 2'd2 : (a[10] ? 2'd1 : 2'd0));
    chk(tag, "R5 win_hit", 32'(win_hit), 32'(e_hit));
    chk(tag, "R7 win_offset", 32'(win_offset), e_hit ? 32'(a[11:0]) : 32'd0);
    chk(tag, "R7 win_region", 32'(win_region), 32'(e_rgn));
    chk(tag, "R3 cfg_sel", 32'(cfg_sel), 32'(e_cfg));
    chk(tag, "R4 base_rd", 32'(base_rd), 32'(m_base));
    chk(tag, "R10 conflict_stat", 32'(conflict_stat), 32'(m_stat));
    chk(tag, "R11 bus_err_req", 32'(bus_err_req), 32'(e_hit && claim && m_en));
    chk(tag, "R12 ext_cs_inhibit", 32'(ext_cs_inhibit), 32'(e_hit || (e_cfg != 7'd0)));
    @(posedge clk);
    #1;
    if (rs && hl) begin
      m_base = 16'hBFFF; m_armed = 1'b0; m_stat = 1'b0; m_en = 1'b0;
    end else begin
      ctl    = w && u && e_cfg[2] && (a[23:1] == 23'h00007A);
      s_next = m_stat;
      if (e_hit && claim)  s_next = 1'b1;
      else if (ctl && d[8]) s_next = 1'b0;
      if (w && e_cfg[1]) begin
        if (u) m_base[15:8] = d[15:8];
        if (l) m_base[7:0]  = d[7:0];
        if (l || (u && !b8)) m_armed = 1'b1;
      end
      if (ctl) m_en = d[9];
      m_stat = s_next;
    end
  endtask

  task automatic rd(input string tag, input logic [23:0] a, input logic [2:0] f);
    cyc(tag, 1'b1, a, f, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [23:0] a, input logic [2:0] f,
                    input logic u, input logic l, input logic [15:0] d);
    cyc(tag, 1'b1, a, f, u, l, 1'b0, 1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic total_reset(input string tag);
    cyc(tag, 1'b0, 24'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL R13 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    rst_req = 1'b1; halt_req = 1'b1; addr_valid = 1'b0; addr = '0; fc = '0;
    ub_en = 1'b0; lb_en = 1'b0; rd_en = 1'b0; wr_en = 1'b0; bus8_mode = 1'b0;
    wdata = '0; ext_claim = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    m_base = 16'hBFFF; m_armed = 1'b0; m_stat = 1'b0; m_en = 1'b0;

    // R1: reset value reads back but the window is closed
    total_reset("R1");
    rd("R1", 24'hFFF000, 3'd5);
    rd("R1", 24'hFFF800, 3'd5);
    // R4: user data space cannot write the base register
    wr("R4", 24'h0000F2, 3'd1, 1'b1, 1'b1, 16'h0012);
    rd("R4", 24'h012000, 3'd1);
    // R8: narrow bus, high byte alone keeps the window shut
    b8 = 1'b1;
    wr("R8", 24'h0000F2, 3'd5, 1'b1, 1'b0, 16'h0000);
    rd("R8", 24'h0FF000, 3'd5);
    wr("R8", 24'h0000F3, 3'd5, 1'b0, 1'b1, 16'h0012);
    rd("R8", 24'h012400, 3'd5);
    rd("R7", 24'h012C05, 3'd5);
    rd("R7", 24'h0123FF, 3'd2);
    // R2: reset without halt keeps everything
    cyc("R2", 1'b0, 24'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0);
    rd("R2", 24'h012000, 3'd5);
    // R8: wide bus, high byte alone opens the window
    total_reset("R1");
    b8 = 1'b0;
    wr("R8", 24'h0000F2, 3'd5, 1'b1, 1'b0, 16'h0300);
    rd("R8", 24'h3FF010, 3'd2);
    // R6: function-code compare
    wr("R6", 24'h0000F2, 3'd5, 1'b1, 1'b1, 16'hB034);
    rd("R6", 24'h034800, 3'd5);
    rd("R6", 24'h034800, 3'd1);
    // R9: window at page 0 loses to configuration addresses
    wr("R9", 24'h0000F2, 3'd5, 1'b1, 1'b1, 16'h0000);
    rd("R9", 24'h0000F2, 3'd5);
    rd("R9", 24'h0000FA, 3'd5);
    rd("R9", 24'h000100, 3'd5);
    // R10 / R11: conflict status and bus error
    wr("R11", 24'h0000F4, 3'd5, 1'b1, 1'b0, 16'h0000);
    cyc("R10", 1'b1, 24'h000300, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    rd("R10", 24'h000300, 3'd5);
    wr("R10", 24'h0000F4, 3'd5, 1'b1, 1'b0, 16'h0100);
    rd("R10", 24'h000300, 3'd5);
    wr("R11", 24'h0000F4, 3'd5, 1'b1, 1'b0, 16'h0200);
    cyc("R11", 1'b1, 24'h000500, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    cyc("R10", 1'b1, 24'h000500, 3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
    wr("R10", 24'h0000F4, 3'd5, 1'b1, 1'b0, 16'h0300);
    // R13: idle bus states
    cyc("R13", 1'b0, 24'h000300, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    cyc("R13", 1'b1, 24'h000300, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    cyc("R13", 1'b0, 24'h0000F2, 3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0);
    // R3: word straddling two registers, single lanes
    rd("R3", 24'h0000F6, 3'd5);
    cyc("R3", 1'b1, 24'h0000F0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    cyc("R3", 1'b1, 24'h0000F8, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    rd("R3", 24'h0000F2, 3'd6);
    total_reset("R1");
    rd("R1", 24'h000300, 3'd5);

    // Constrained random traffic
    for (int i = 0; i < 600; i++) begin
      logic [23:0] a;
      logic [2:0]  f;
      logic        u, l, w, rs, hl;
      case ($urandom % 4)
        0:       a = {m_base[11:0], 12'($urandom)};
        1:       a = 24'h0000F0 + 24'($urandom % 16);
        2:       a = 24'($urandom);
        default: a = {m_base[11:0], 2'($urandom), 10'h0};
      endcase
      f  = ($urandom % 2 == 0) ? 3'd5 : 3'($urandom);
      u  = 1'($urandom);
      l  = 1'($urandom);
      w  = ($urandom % 4 == 0);
      rs = ($urandom % 40 == 0);
      hl = rs && 1'($urandom);
      if ($urandom % 16 == 0) b8 = ~b8;
      cyc("R5", ($urandom % 8 != 0), a, f, u, l, !w, w, 16'($urandom),
          ($urandom % 4 == 0), rs, hl);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule